// File: doc/BRIEF.md
# Dual-Issue Lockstep Pipeline Controller

This block sequences instruction tags through two parallel integer pipes, U and V. Each pipe has five stages: prefetch, first decode, second decode, execute and writeback. The controller does no arithmetic. Each cycle it looks at the two oldest fetched instructions, decides whether they may issue as a pair, and moves tag and valid bits down a shared stage ladder. Because of that ladder the two pipes can never slip relative to each other.

Prefetch is the fetch unit's own presentation of two candidate slots. The oldest candidate is in slot 0 and the next one is in slot 1. Each slot carries a valid bit, a class code and a tag. `take_o` tells the fetch unit how many candidates were consumed. The stages after prefetch are registers inside the block.

A stall request raised at any stage of either pipe freezes that stage and every earlier stage in both pipes. Later stages keep draining. A flush empties every stage behind prefetch at once.

Top module: `lockstep_issue_ctrl`

## Requirements
- R1: Two candidates issue as a pair only when both slots are valid and both class codes are in the simple group. The class codes are 0 = ALU, 1 = memory, 2 = jump, 3 = shift and 4 = complex, and the simple group is 0, 1 and 2. A pair sets `paired_o` and `take_o` = 2, and the next cycle shows the slot 0 tag in U and the slot 1 tag in V of stage 1.
- R2: When two simple candidates cannot pair for any other reason, the older one issues alone into U. `take_o` = 1, and V of stage 1 holds a bubble in the next cycle.
- R3: A shift-class or complex-class candidate never issues as part of a pair, in either slot. A shift or complex instruction in slot 0 issues alone into U, so the V pipe never receives one.
- R4: A stall request at stage s of either pipe clears `adv_o` for stage s and for every earlier stage. Each stage from 1 up to s keeps its U and V contents unchanged in the next cycle.
- R5: Stages after the highest stalled stage keep advancing. The stage just after a frozen stage receives a bubble in both pipes.
- R6: The pipes stay in lockstep. A valid V entry at any stage always has a valid U entry at the same stage, and a pair reaches writeback together.
- R7: `flush_i` empties stages 1 to 4 of both pipes in the next cycle, even when stalls are raised in the same cycle. Nothing issues in a flush cycle.
- R8: Nothing issues while slot 0 is empty, whatever slot 1 holds. `take_o` never exceeds 2.
- R9: After reset, stages 1 to 4 of both pipes are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty all stages behind prefetch |
| fetch_vld_i | input | 2 | Candidate valid, bit 0 = older slot |
| fetch_cls0_i | input | 3 | Class code of slot 0 |
| fetch_cls1_i | input | 3 | Class code of slot 1 |
| fetch_tag0_i | input | TAG_W | Tag of slot 0 |
| fetch_tag1_i | input | TAG_W | Tag of slot 1 |
| stall_u_i | input | N_STG | Per-stage stall request, U pipe |
| stall_v_i | input | N_STG | Per-stage stall request, V pipe |
| take_o | output | 2 | Candidates consumed this cycle |
| paired_o | output | 1 | Two candidates issued together |
| adv_o | output | N_STG | Stage advances this cycle (both pipes) |
| u_vld_o | output | N_STG | U stage occupancy (bit 0 mirrors slot 0) |
| v_vld_o | output | N_STG | V stage occupancy (bit 0 mirrors slot 1) |
| u_tag_o | output | N_STG*TAG_W | U stage tags, stage s at bits s*TAG_W |
| v_tag_o | output | N_STG*TAG_W | V stage tags, stage s at bits s*TAG_W |

## Verification
The bench sweeps all 25 class pairs under every slot-valid pattern. A pairing rule that checked only one slot, or that treated shift as simple, would put a shifter instruction into V and would fail the take and stage-1 comparisons. Stalls are applied at every stage of each pipe, one and two cycles long. A controller that froze only the requesting pipe, or that duplicated an entry instead of inserting a bubble after the frozen stage, would show diverging U and V contents. Flush is hit together with stalls and with valid candidates, which catches a flush that loses to a hold or that still issues. A long pseudo-random mix then compares every stage against an arithmetic model.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_ALU = 3'd0,
      CLS_MEM = 3'd1,
      CLS_JMP = 3'd2,
      CLS_SHF = 3'd3,
      CLS_CPX = 3'd4
   } iclass_e;

   // Classes allowed in the secondary pipe and in a pair
   function automatic logic is_pairable(input logic [CLS_W-1:0] c);
      return (c == CLS_ALU) || (c == CLS_MEM) || (c == CLS_JMP);
   endfunction
endpackage

// File: rtl/lsp_pair_gate.sv
module lsp_pair_gate
   import lsp_pkg::*;
#(
   parameter bit DUAL_ISSUE = 1'b1
) (
   input  logic [1:0]       vld_i,
   input  logic [CLS_W-1:0] cls0_i,
   input  logic [CLS_W-1:0] cls1_i,
   output logic             pair_o
);
   generate
      if (DUAL_ISSUE) begin : g_dual
         assign pair_o = vld_i[0] & vld_i[1] & is_pairable(cls0_i) & is_pairable(cls1_i);
      end else begin : g_single
         logic unused_in;
         assign unused_in = ^{vld_i, cls0_i, cls1_i};
         assign pair_o    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lsp_hold_chain.sv
module lsp_hold_chain #(
   parameter int N_STG = 5
) (
   input  logic [N_STG-1:0] stall_u_i,
   input  logic [N_STG-1:0] stall_v_i,
   output logic [N_STG-1:0] hold_o
);
   logic [N_STG-1:0] any_stall;
   assign any_stall = stall_u_i | stall_v_i;

   // A frozen stage blocks every stage feeding it, in both pipes
   always_comb begin
      hold_o[N_STG-1] = any_stall[N_STG-1];
      for (int s = N_STG - 2; s >= 0; s--) begin
         hold_o[s] = any_stall[s] | hold_o[s+1];
      end
   end
endmodule

// File: rtl/lsp_stage.sv
module lsp_stage #(
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             hold_self_i,
   input  logic             hold_prev_i,
   input  logic             u_vld_i,
   input  logic [TAG_W-1:0] u_tag_i,
   input  logic             v_vld_i,
   input  logic [TAG_W-1:0] v_tag_i,
   output logic             u_vld_o,
   output logic [TAG_W-1:0] u_tag_o,
   output logic             v_vld_o,
   output logic [TAG_W-1:0] v_tag_o
);
   logic load;
   assign load = !flush_i && !hold_self_i && !hold_prev_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         u_vld_o <= 1'b0;
         v_vld_o <= 1'b0;
      end else if (flush_i) begin
         u_vld_o <= 1'b0;
         v_vld_o <= 1'b0;
      end else if (!hold_self_i) begin
         u_vld_o <= hold_prev_i ? 1'b0 : u_vld_i;
         v_vld_o <= hold_prev_i ? 1'b0 : v_vld_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         u_tag_o <= '0;
         v_tag_o <= '0;
      end else if (load) begin
         u_tag_o <= u_tag_i;
         v_tag_o <= v_tag_i;
      end
   end
endmodule

// File: rtl/lockstep_issue_ctrl.sv
module lockstep_issue_ctrl
   import lsp_pkg::*;
#(
   parameter int N_STG      = 5,
   parameter int TAG_W      = 8,
   parameter bit DUAL_ISSUE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush_i,
   input  logic [1:0]             fetch_vld_i,
   input  logic [2:0]             fetch_cls0_i,
   input  logic [2:0]             fetch_cls1_i,
   input  logic [TAG_W-1:0]       fetch_tag0_i,
   input  logic [TAG_W-1:0]       fetch_tag1_i,
   input  logic [N_STG-1:0]       stall_u_i,
   input  logic [N_STG-1:0]       stall_v_i,
   output logic [1:0]             take_o,
   output logic                   paired_o,
   output logic [N_STG-1:0]       adv_o,
   output logic [N_STG-1:0]       u_vld_o,
   output logic [N_STG-1:0]       v_vld_o,
   output logic [N_STG*TAG_W-1:0] u_tag_o,
   output logic [N_STG*TAG_W-1:0] v_tag_o
);
   localparam int TAG_BITS = N_STG * TAG_W;

   generate
      if (N_STG < 3) begin : g_bad_depth
         $error("lockstep_issue_ctrl: N_STG must be at least 3");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("lockstep_issue_ctrl: TAG_W must be at least 1");
      end
      if (CLS_W != 3) begin : g_bad_cls
         $error("lockstep_issue_ctrl: class code width mismatch");
      end
   endgenerate

   logic [N_STG-1:0] hold;
   logic             pair_ok;
   logic             issue;

   logic             st_uv [N_STG];
   logic             st_vv [N_STG];
   logic [TAG_W-1:0] st_ut [N_STG];
   logic [TAG_W-1:0] st_vt [N_STG];

   lsp_hold_chain #(.N_STG(N_STG)) u_hold (
      .stall_u_i (stall_u_i),
      .stall_v_i (stall_v_i),
      .hold_o    (hold)
   );

   lsp_pair_gate #(.DUAL_ISSUE(DUAL_ISSUE)) u_pair (
      .vld_i  (fetch_vld_i),
      .cls0_i (fetch_cls0_i),
      .cls1_i (fetch_cls1_i),
      .pair_o (pair_ok)
   );

   assign issue    = !flush_i && !hold[0] && fetch_vld_i[0];
   assign paired_o = issue && pair_ok;
   assign take_o   = issue ? (pair_ok ? 2'd2 : 2'd1) : 2'd0;
   assign adv_o    = ~hold;

   // Prefetch row: the fetch unit's candidate slots
   assign st_uv[0] = fetch_vld_i[0];
   assign st_vv[0] = fetch_vld_i[1];
   assign st_ut[0] = fetch_tag0_i;
   assign st_vt[0] = fetch_tag1_i;

   generate
      for (genvar s = 1; s < N_STG; s++) begin : g_stg
         logic             in_uv;
         logic             in_vv;
         logic [TAG_W-1:0] in_ut;
         logic [TAG_W-1:0] in_vt;

         if (s == 1) begin : g_entry
            assign in_uv = issue;
            assign in_vv = paired_o;
            assign in_ut = fetch_tag0_i;
            assign in_vt = fetch_tag1_i;
         end else begin : g_chain
            assign in_uv = st_uv[s-1];
            assign in_vv = st_vv[s-1];
            assign in_ut = st_ut[s-1];
            assign in_vt = st_vt[s-1];
         end

         lsp_stage #(.TAG_W(TAG_W)) u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_i),
            .hold_self_i (hold[s]),
            .hold_prev_i (hold[s-1]),
            .u_vld_i     (in_uv),
            .u_tag_i     (in_ut),
            .v_vld_i     (in_vv),
            .v_tag_i     (in_vt),
            .u_vld_o     (st_uv[s]),
            .u_tag_o     (st_ut[s]),
            .v_vld_o     (st_vv[s]),
            .v_tag_o     (st_vt[s])
         );
      end

      for (genvar s = 0; s < N_STG; s++) begin : g_out
         assign u_vld_o[s]                = st_uv[s];
         assign v_vld_o[s]                = st_vv[s];
         assign u_tag_o[s*TAG_W +: TAG_W] = st_ut[s];
         assign v_tag_o[s*TAG_W +: TAG_W] = st_vt[s];
      end
   endgenerate

   logic [TAG_BITS-1:0] unused_width_probe;
   assign unused_width_probe = '0;
endmodule

// File: rtl/lsp_checker.sv
module lsp_checker #(
   parameter int N_STG = 5,
   parameter int TAG_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   flush_i,
   input logic [1:0]             fetch_vld_i,
   input logic [2:0]             fetch_cls0_i,
   input logic [2:0]             fetch_cls1_i,
   input logic [N_STG-1:0]       stall_u_i,
   input logic [N_STG-1:0]       stall_v_i,
   input logic [1:0]             take_o,
   input logic                   paired_o,
   input logic [N_STG-1:0]       adv_o,
   input logic [N_STG-1:0]       u_vld_o,
   input logic [N_STG-1:0]       v_vld_o,
   input logic [N_STG*TAG_W-1:0] u_tag_o,
   input logic [N_STG*TAG_W-1:0] v_tag_o
);
   a_r1_pair_simple_only: assert property (@(posedge clk) disable iff (!rst_n)
      paired_o |-> (fetch_vld_i == 2'b11 && fetch_cls0_i <= 3'd2 && fetch_cls1_i <= 3'd2));

   a_r3_heavy_never_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_cls0_i >= 3'd3 || fetch_cls1_i >= 3'd3) |-> !paired_o);

   a_r8_take_two_is_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o == 2'd2) == paired_o);

   a_r8_no_issue_empty_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_vld_i[0] |-> (take_o == 2'd0 && take_o != 2'd3));

   a_r7_no_issue_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> take_o == 2'd0);

   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (u_vld_o[N_STG-1:1] == '0 && v_vld_o[N_STG-1:1] == '0));

   generate
      for (genvar s = 0; s < N_STG; s++) begin : g_chk
         a_r4_stall_blocks_adv: assert property (@(posedge clk) disable iff (!rst_n)
            (stall_u_i[s] || stall_v_i[s]) |-> !adv_o[s]);

         if (s > 0) begin : g_reg
            a_r6_v_needs_u: assert property (@(posedge clk) disable iff (!rst_n)
               v_vld_o[s] |-> u_vld_o[s]);

            a_r4_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
               (!flush_i && !adv_o[s]) |=> ($stable(u_vld_o[s]) && $stable(v_vld_o[s])
                  && $stable(u_tag_o[s*TAG_W +: TAG_W]) && $stable(v_tag_o[s*TAG_W +: TAG_W])));
         end

         if (s < N_STG - 1) begin : g_pair
            a_r4_freeze_spreads_back: assert property (@(posedge clk) disable iff (!rst_n)
               !adv_o[s+1] |-> !adv_o[s]);

            a_r5_bubble_after_freeze: assert property (@(posedge clk) disable iff (!rst_n)
               (!flush_i && !adv_o[s] && adv_o[s+1]) |=> (!u_vld_o[s+1] && !v_vld_o[s+1]));
         end
      end
   endgenerate
endmodule

bind lockstep_issue_ctrl lsp_checker #(.N_STG(N_STG), .TAG_W(TAG_W)) u_lsp_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush_i      (flush_i),
   .fetch_vld_i  (fetch_vld_i),
   .fetch_cls0_i (fetch_cls0_i),
   .fetch_cls1_i (fetch_cls1_i),
   .stall_u_i    (stall_u_i),
   .stall_v_i    (stall_v_i),
   .take_o       (take_o),
   .paired_o     (paired_o),
   .adv_o        (adv_o),
   .u_vld_o      (u_vld_o),
   .v_vld_o      (v_vld_o),
   .u_tag_o      (u_tag_o),
   .v_tag_o      (v_tag_o)
);

// File: tb/tb_lockstep_issue_ctrl.sv
module tb_lockstep_issue_ctrl;
   localparam int N  = 5;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic [1:0]    fvld = '0;
   logic [2:0]    cls0 = '0, cls1 = '0;
   logic [TW-1:0] tag0 = '0, tag1 = '0;
   logic [N-1:0]  stu = '0, stv = '0;
   logic [1:0]    take_o;
   logic          paired_o;
   logic [N-1:0]  adv_o, u_vld_o, v_vld_o;
   logic [N*TW-1:0] u_tag_o, v_tag_o;

   int n_chk = 0, n_fail = 0;
   logic [TW-1:0] ntag = 8'd1;
   logic          m_uv [N];
   logic          m_vv [N];
   logic [TW-1:0] m_ut [N];
   logic [TW-1:0] m_vt [N];
   logic [31:0]   rs = 32'h1234_5678;

   always #2 clk = ~clk;

   lockstep_issue_ctrl #(.N_STG(N), .TAG_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .fetch_vld_i(fvld),
      .fetch_cls0_i(cls0), .fetch_cls1_i(cls1), .fetch_tag0_i(tag0), .fetch_tag1_i(tag1),
      .stall_u_i(stu), .stall_v_i(stv), .take_o(take_o), .paired_o(paired_o),
      .adv_o(adv_o), .u_vld_o(u_vld_o), .v_vld_o(v_vld_o), .u_tag_o(u_tag_o), .v_tag_o(v_tag_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cmp_regs(input string req);
      logic [N-1:0]    euv, evv, auv, avv;
      logic [N*TW-1:0] eut, evt, aut, avt;
      euv = '0; evv = '0; auv = '0; avv = '0; eut = '0; evt = '0; aut = '0; avt = '0;
      for (int s = 1; s < N; s++) begin
         euv[s] = m_uv[s]; evv[s] = m_vv[s];
         auv[s] = u_vld_o[s]; avv[s] = v_vld_o[s];
         if (m_uv[s]) eut[s*TW +: TW] = m_ut[s];
         if (m_vv[s]) evt[s*TW +: TW] = m_vt[s];
         if (u_vld_o[s]) aut[s*TW +: TW] = u_tag_o[s*TW +: TW];
         if (v_vld_o[s]) avt[s*TW +: TW] = v_tag_o[s*TW +: TW];
      end
      chk(auv == euv && avv == evv, req, "stage valids", {auv, avv}, {euv, evv});
      chk(aut == eut, req, "U tags", 64'(aut), 64'(eut));
      chk(avt == evt, req, "V tags", 64'(avt), 64'(evt));
   endtask

   // Drive one cycle at the falling edge, check combinational and next-state results
   task automatic step(input logic fl, input logic [1:0] vv, input logic [2:0] c0, input logic [2:0] c1,
                       input logic [N-1:0] su, input logic [N-1:0] sv, input string lc, input string lr);
      logic [N-1:0] h;
      logic pr, iss, ep;
      logic [1:0] et;
      logic          nuv [N];
      logic          nvv [N];
      logic [TW-1:0] nut [N];
      logic [TW-1:0] nvt [N];
      flush = fl; fvld = vv; cls0 = c0; cls1 = c1; stu = su; stv = sv;
      tag0 = ntag; tag1 = ntag + 8'd1;
      #1;
      h[N-1] = su[N-1] | sv[N-1];
      for (int s = N - 2; s >= 0; s--) h[s] = su[s] | sv[s] | h[s+1];
      pr  = (vv == 2'b11) && (c0 <= 3'd2) && (c1 <= 3'd2);
      iss = !fl && !h[0] && vv[0];
      et  = iss ? (pr ? 2'd2 : 2'd1) : 2'd0;
      ep  = iss && pr;
      chk(take_o == et && paired_o == ep, lc, "take/paired", 64'({take_o, paired_o}), 64'({et, ep}));
      chk(adv_o == ~h, "R4", "advance", 64'(adv_o), 64'(~h));
      nuv[0] = 1'b0; nvv[0] = 1'b0; nut[0] = '0; nvt[0] = '0;
      for (int s = 1; s < N; s++) begin
         nuv[s] = m_uv[s]; nvv[s] = m_vv[s]; nut[s] = m_ut[s]; nvt[s] = m_vt[s];
         if (fl) begin
            nuv[s] = 1'b0; nvv[s] = 1'b0;
         end else if (!h[s]) begin
            if (h[s-1]) begin
               nuv[s] = 1'b0; nvv[s] = 1'b0;
            end else if (s == 1) begin
               nuv[s] = iss; nut[s] = tag0; nvv[s] = ep; nvt[s] = tag1;
            end else begin
               nuv[s] = m_uv[s-1]; nvv[s] = m_vv[s-1]; nut[s] = m_ut[s-1]; nvt[s] = m_vt[s-1];
            end
         end
      end
      ntag = ntag + 8'(et);
      @(posedge clk);
      @(negedge clk);
      for (int s = 1; s < N; s++) begin
         m_uv[s] = nuv[s]; m_vv[s] = nvv[s]; m_ut[s] = nut[s]; m_vt[s] = nvt[s];
      end
      cmp_regs(lr);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'b00, 3'd0, 3'd0, '0, '0, "R8", "R6");
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] r);
      logic [31:0] x;
      x = r ^ (r << 13);
      x = x ^ (x >> 17);
      return x ^ (x << 5);
   endfunction

   initial begin
      for (int s = 0; s < N; s++) begin
         m_uv[s] = 1'b0; m_vv[s] = 1'b0; m_ut[s] = '0; m_vt[s] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      cmp_regs("R9");
      chk(take_o == 2'd0, "R9", "take after reset", 64'(take_o), 64'd0);
      @(negedge clk);

      // Every class pair under every slot-valid pattern
      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int v = 1; v < 4; v++) begin
               string lc;
               if (v == 2) lc = "R8";
               else if (a >= 3 || b >= 3) lc = "R3";
               else if (v == 3) lc = "R1";
               else lc = "R2";
               step(1'b0, 2'(v), 3'(a), 3'(b), '0, '0, lc, "R6");
            end
      idle(N);

      // Stalls at each stage of each pipe, one and two cycles long
      for (int s = 0; s < N; s++)
         for (int p = 0; p < 2; p++)
            for (int len = 1; len <= 2; len++) begin
               logic [N-1:0] sm;
               sm = '0; sm[s] = 1'b1;
               for (int i = 0; i < 4; i++) step(1'b0, 2'b11, 3'd0, 3'd1, '0, '0, "R1", "R6");
               for (int i = 0; i < len; i++)
                  step(1'b0, 2'b11, 3'd2, 3'd0, p ? '0 : sm, p ? sm : '0, "R4", "R5");
               step(1'b0, 2'b01, 3'd3, 3'd0, '0, '0, "R3", "R5");
            end

      // Flush, alone and together with stalls and valid candidates
      for (int i = 0; i < 4; i++) step(1'b0, 2'b11, 3'd1, 3'd1, '0, '0, "R1", "R6");
      step(1'b1, 2'b11, 3'd0, 3'd0, 5'b00100, 5'b01000, "R7", "R7");
      for (int i = 0; i < 3; i++) step(1'b0, 2'b11, 3'd0, 3'd2, '0, '0, "R1", "R6");
      step(1'b1, 2'b01, 3'd4, 3'd0, '0, '0, "R7", "R7");

      // Pseudo-random mix
      for (int i = 0; i < 3000; i++) begin
         logic fl;
         logic [N-1:0] su, sv;
         rs = nxt(rs);
         fl = (rs[4:0] == 5'd0);
         for (int s = 0; s < N; s++) begin
            su[s] = (rs[5+s*3 +: 3] == 3'd0);
            sv[s] = (rs[6+s*3 +: 2] == 2'd3) && rs[31];
         end
         step(fl, rs[22:21], 3'(rs[25:23] % 5), 3'(rs[28:26] % 5), su, sv, "R6", "R6");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule